// File: doc/BRIEF.md
# Directed-Mode Mantissa Rounding Unit

This block is a combinational rounding stage that sits behind a floating-point datapath that has already aligned its result. The caller supplies the sign, a mantissa whose two lowest bits hold the guard bit (bit 1) and the round bit (bit 0), and a separate sticky bit that collects everything shifted out further down. The block drops the guard and round bits and decides, from a 2-bit direction selector, whether to add one unit in the last place. The result comes back with a carry-out flag and with flags for inexactness and for an applied increment.

The same selector also settles how an overflowing result saturates. Depending on the direction and the sign, the result goes to infinity or stays at the largest finite magnitude. The caller uses that decision when its exponent logic reports an overflow.

Renormalising a carry into the next binade, exponent arithmetic and packing into a storage format all belong to the caller. The direction selector encodes 00 as nearest-even, 01 as toward zero, 10 as toward plus infinity and 11 as toward minus infinity. All outputs are purely combinational.

Top module: `rnd_dir_unit`

## Requirements
- R1: `mant_o` equals `mant_i` shifted right by two, plus one when an increment is applied. The guard bit (bit 1) and the round bit (bit 0) are always discarded.
- R2: When guard, round and sticky are all zero, no increment is applied and `inexact_o` and `frac_inexact_o` are both 0.
- R3: When any of guard, round or sticky is 1, both `inexact_o` and `frac_inexact_o` are 1.
- R4: In nearest mode (`mode_i`=00), an increment is applied only when guard is 1 and at least one of these is 1: round, sticky, or bit 0 of the shifted mantissa. A pure tie rounds to an even result.
- R5: In toward-zero mode (`mode_i`=01), no increment is ever applied.
- R6: In toward-plus-infinity mode (`mode_i`=10), an inexact value is incremented only when `sign_i`=0. In toward-minus-infinity mode (`mode_i`=11), an inexact value is incremented only when `sign_i`=1.
- R7: When an increment is applied, both `rounded_up_o` and `frac_rounded_o` are 1 and the carry ripples through the full shifted width. When no increment is applied, both flags are 0.
- R8: If an increment carries out of the top bit of the shifted mantissa, `carry_o` is 1 and `mant_o` is all zeros. The block does not correct this result.
- R9: `ovf_inf_o` (the overflow flag, 1 = saturate to infinity) depends only on mode and sign. It is always 1 in nearest mode and always 0 in toward-zero mode. In plus-infinity mode it is 1 only for `sign_i`=0, and in minus-infinity mode only for `sign_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sign_i | input | 1 | Sign of the value, 1 = negative |
| mant_i | input | MANT_W | Mantissa; bit 1 is guard, bit 0 is round |
| sticky_i | input | 1 | OR of all bits below the round bit |
| mode_i | input | 2 | Direction: 00 nearest, 01 zero, 10 +inf, 11 -inf |
| mant_o | output | MANT_W-2 | Shifted and possibly incremented mantissa |
| carry_o | output | 1 | Increment carried out of the top bit |
| rounded_up_o | output | 1 | An increment was applied |
| inexact_o | output | 1 | Input was not exactly representable |
| frac_inexact_o | output | 1 | Fraction was inexact |
| frac_rounded_o | output | 1 | Fraction was rounded up |
| ovf_inf_o | output | 1 | On overflow, saturate to infinity (else to largest finite) |

## Verification
The block holds no state, so any internal fault shows at the ports in the same evaluation as the input pattern that exercises it. A wrong increment decision appears as a `mant_o` that differs by one from the truncated value, together with mismatched `rounded_up_o`. A broken carry chain shows only when a long run of ones sits above the guard bit, so the bench drives an all-ones mantissa as well as random ones. A swapped sign or mode term in the direction logic shows only on patterns with the opposite sign, so every direction is driven with both signs.

// File: rtl/rnd_pkg.sv
package rnd_pkg;

  typedef enum logic [1:0] {
    RND_NEAR = 2'b00,
    RND_ZERO = 2'b01,
    RND_PINF = 2'b10,
    RND_MINF = 2'b11
  } rnd_mode_e;

endpackage

// File: rtl/rnd_incr_decide.sv
module rnd_incr_decide
  import rnd_pkg::*;
(
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  input  logic      guard_i,
  input  logic      rbit_i,
  input  logic      sticky_i,
  input  logic      lsb_i,
  output logic      inexact_o,
  output logic      inc_o
);

  logic lost;

  always_comb begin
    lost = guard_i | rbit_i | sticky_i;
    inc_o = 1'b0;
    if (lost) begin
      unique case (mode_i)
        RND_ZERO: inc_o = 1'b0;
        RND_PINF: inc_o = ~sign_i;
        RND_MINF: inc_o = sign_i;
        default:  inc_o = guard_i & (rbit_i | sticky_i | lsb_i);
      endcase
    end
    inexact_o = lost;
  end

endmodule

// File: rtl/rnd_mant_adder.sv
module rnd_mant_adder #(
  parameter int unsigned WIDTH = 30
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic             inc_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);

  logic [WIDTH:0] cy;

  assign cy[0] = inc_i;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign sum_o[b]  = a_i[b] ^ cy[b];
    assign cy[b+1]   = a_i[b] & cy[b];
  end

  assign cout_o = cy[WIDTH];

endmodule

// File: rtl/rnd_ovf_select.sv
module rnd_ovf_select
  import rnd_pkg::*;
(
  input  logic      sign_i,
  input  rnd_mode_e mode_i,
  output logic      to_inf_o
);

  always_comb begin
    unique case (mode_i)
      RND_ZERO: to_inf_o = 1'b0;
      RND_PINF: to_inf_o = ~sign_i;
      RND_MINF: to_inf_o = sign_i;
      default:  to_inf_o = 1'b1;
    endcase
  end

endmodule

// File: rtl/rnd_dir_unit.sv
module rnd_dir_unit
  import rnd_pkg::*;
#(
  parameter int unsigned MANT_W = 32
) (
  input  logic              sign_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic              sticky_i,
  input  logic [1:0]        mode_i,
  output logic [MANT_W-3:0] mant_o,
  output logic              carry_o,
  output logic              rounded_up_o,
  output logic              inexact_o,
  output logic              frac_inexact_o,
  output logic              frac_rounded_o,
  output logic              ovf_inf_o
);

  localparam int unsigned FRAC_W = MANT_W - 2;

  rnd_mode_e         mode;
  logic [FRAC_W-1:0] shifted;
  logic              inc;
  logic              lost;

  assign mode    = rnd_mode_e'(mode_i);
  assign shifted = mant_i[MANT_W-1:2];

  rnd_incr_decide u_decide (
    .sign_i   (sign_i),
    .mode_i   (mode),
    .guard_i  (mant_i[1]),
    .rbit_i   (mant_i[0]),
    .sticky_i (sticky_i),
    .lsb_i    (shifted[0]),
    .inexact_o(lost),
    .inc_o    (inc)
  );

  rnd_mant_adder #(.WIDTH(FRAC_W)) u_adder (
    .a_i   (shifted),
    .inc_i (inc),
    .sum_o (mant_o),
    .cout_o(carry_o)
  );

  rnd_ovf_select u_ovf (
    .sign_i  (sign_i),
    .mode_i  (mode),
    .to_inf_o(ovf_inf_o)
  );

  assign rounded_up_o   = inc;
  assign frac_rounded_o = inc;
  assign inexact_o      = lost;
  assign frac_inexact_o = lost;

  always_comb begin
    AST_EXACT_NO_INC: assert (!(mant_i[1:0] == 2'b00 && !sticky_i) || !rounded_up_o); // R2
    AST_NEAR_NEEDS_GUARD: assert (!(mode_i == 2'b00 && !mant_i[1]) || !rounded_up_o); // R4
    AST_ZERO_NEVER_INC: assert (mode_i != 2'b01 || !rounded_up_o); // R5
    AST_PINF_NEG_NO_INC: assert (!(mode_i == 2'b10 && sign_i) || !rounded_up_o); // R6
    AST_MINF_POS_NO_INC: assert (!(mode_i == 2'b11 && !sign_i) || !rounded_up_o); // R6
    AST_CARRY_NEEDS_INC: assert (!carry_o || (rounded_up_o && mant_o == '0)); // R8
    AST_ZERO_NO_INF: assert (mode_i != 2'b01 || !ovf_inf_o); // R9
    AST_NEAR_ALWAYS_INF: assert (mode_i != 2'b00 || ovf_inf_o); // R9
  end

endmodule

// File: tb/rnd_dir_unit_tb_top.sv
module rnd_dir_unit_tb_top;

  localparam int unsigned MW = 32;
  localparam int unsigned FW = MW - 2;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic          sign_i, sticky_i;
  logic [MW-1:0] mant_i;
  logic [1:0]    mode_i;
  logic [FW-1:0] mant_o;
  logic carry_o, rounded_up_o, inexact_o, frac_inexact_o, frac_rounded_o, ovf_inf_o;

  rnd_dir_unit #(.MANT_W(MW)) dut_i (
    .sign_i(sign_i), .mant_i(mant_i), .sticky_i(sticky_i), .mode_i(mode_i),
    .mant_o(mant_o), .carry_o(carry_o), .rounded_up_o(rounded_up_o),
    .inexact_o(inexact_o), .frac_inexact_o(frac_inexact_o),
    .frac_rounded_o(frac_rounded_o), .ovf_inf_o(ovf_inf_o)
  );

  typedef struct packed {
    logic          s;
    logic [1:0]    md;
    logic          st;
    logic [MW-1:0] m;
    logic [FW-1:0] em;
    logic          ec;
    logic          up;
    logic          ix;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 2'd0, 1'b0, 32'h10, 30'h4, 1'b0, 1'b0, 1'b0},         // R2 exact
    '{1'b0, 2'd0, 1'b0, 32'h12, 30'h4, 1'b0, 1'b0, 1'b1},         // R4 tie even
    '{1'b0, 2'd0, 1'b0, 32'h16, 30'h6, 1'b0, 1'b1, 1'b1},         // R4 tie odd
    '{1'b0, 2'd0, 1'b0, 32'h13, 30'h5, 1'b0, 1'b1, 1'b1},         // R4 guard+round
    '{1'b0, 2'd0, 1'b1, 32'h12, 30'h5, 1'b0, 1'b1, 1'b1},         // R4 guard+sticky
    '{1'b0, 2'd0, 1'b0, 32'h11, 30'h4, 1'b0, 1'b0, 1'b1},         // R4 no guard
    '{1'b0, 2'd1, 1'b1, 32'h17, 30'h5, 1'b0, 1'b0, 1'b1},         // R5
    '{1'b0, 2'd2, 1'b0, 32'h11, 30'h5, 1'b0, 1'b1, 1'b1},         // R6 +inf pos
    '{1'b1, 2'd2, 1'b0, 32'h11, 30'h4, 1'b0, 1'b0, 1'b1},         // R6 +inf neg
    '{1'b1, 2'd3, 1'b0, 32'h11, 30'h5, 1'b0, 1'b1, 1'b1},         // R6 -inf neg
    '{1'b0, 2'd3, 1'b0, 32'h11, 30'h4, 1'b0, 1'b0, 1'b1},         // R6 -inf pos
    '{1'b0, 2'd2, 1'b1, 32'h10, 30'h5, 1'b0, 1'b1, 1'b1},         // R3 sticky only
    '{1'b0, 2'd0, 1'b0, 32'hFFFF_FFFF, 30'h0, 1'b1, 1'b1, 1'b1},  // R8 carry out
    '{1'b0, 2'd2, 1'b0, 32'h20, 30'h8, 1'b0, 1'b0, 1'b0}          // R2 exact +inf
  };

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic [1:0] md, input logic st, input logic [MW-1:0] m);
    @(negedge clk);
    sign_i = s; mode_i = md; sticky_i = st; mant_i = m;
    #1;
  endtask

  function automatic logic ref_inf(input logic s, input logic [1:0] md);
    case (md)
      2'd1: return 1'b0;
      2'd2: return !s;
      2'd3: return s;
      default: return 1'b1;
    endcase
  endfunction

  initial begin
    rst_n = 1'b0;
    sign_i = 1'b0; mode_i = 2'd0; sticky_i = 1'b0; mant_i = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Idle state: all-zero inputs give all-zero outputs (R2)
    drive(1'b0, 2'd1, 1'b0, '0);
    chk(mant_o == '0 && !rounded_up_o && !inexact_o && !carry_o, "R2 idle",
        {mant_o, rounded_up_o, inexact_o}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].s, VECS[i].md, VECS[i].st, VECS[i].m);
      chk(mant_o == VECS[i].em, "R1 mant", mant_o, VECS[i].em);
      chk(carry_o == VECS[i].ec, "R8 carry", carry_o, VECS[i].ec);
      chk(rounded_up_o == VECS[i].up && frac_rounded_o == VECS[i].up, "R7 up flags",
          {rounded_up_o, frac_rounded_o}, {VECS[i].up, VECS[i].up});
      chk(inexact_o == VECS[i].ix && frac_inexact_o == VECS[i].ix, "R3 inexact flags",
          {inexact_o, frac_inexact_o}, {VECS[i].ix, VECS[i].ix});
    end

    // R9 overflow decision, every mode and sign
    for (int md = 0; md < 4; md++) begin
      for (int s = 0; s < 2; s++) begin
        drive(s[0], md[1:0], 1'b0, 32'h4);
        chk(ovf_inf_o == ref_inf(s[0], md[1:0]), "R9 ovf", ovf_inf_o, ref_inf(s[0], md[1:0]));
      end
    end

    // Random patterns in every mode against a reference model (R1 R4 R5 R6 R7)
    for (int i = 0; i < 800; i++) begin
      logic [MW-1:0] m;
      logic s, st, lost, up;
      logic [1:0] md;
      logic [FW:0] sum;
      m = $urandom;
      if (i % 7 == 0) m[MW-1:2] = '1;
      s = $urandom_range(0, 1);
      st = $urandom_range(0, 1);
      md = 2'(i % 4);
      lost = m[1] || m[0] || st;
      if (!lost) up = 1'b0;
      else if (md == 2'd0) up = m[1] && (m[0] || st || m[2]);
      else if (md == 2'd1) up = 1'b0;
      else if (md == 2'd2) up = !s;
      else up = s;
      sum = {1'b0, m[MW-1:2]} + (FW+1)'(up);
      drive(s, md, st, m);
      chk(mant_o == sum[FW-1:0], "R1 random mant", mant_o, sum[FW-1:0]);
      chk(carry_o == sum[FW], "R8 random carry", carry_o, sum[FW]);
      chk(rounded_up_o == up, "R4 R5 R6 R7 random up", rounded_up_o, up);
      chk(inexact_o == lost, "R3 random inexact", inexact_o, lost);
      chk(ovf_inf_o == ref_inf(s, md), "R9 random ovf", ovf_inf_o, ref_inf(s, md));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule